// File: doc/BRIEF.md
# Vectored Priority Interrupt Arbiter

This block sits after the per-class masking logic of an interrupt controller. It looks at the already-masked pending sources of two request classes: a normal class and a fast class. Every source carries a 3-bit priority, and a value of 0 is the most urgent. For each class the block selects the most urgent active source. It raises the class request line only when that source would preempt the handler that is currently running. It also offers software a ready-made handler address, built from a 16-bit base field and the 5-bit index of the winning source.

Nesting is tracked in a small in-service stack for each class. The stack holds the priority of every handler that has been entered and not yet finished. Reading the class vector while its request is high acknowledges the interrupt and pushes the winner's priority. An end-of-interrupt strobe pops one entry. Vectored operation is enabled separately for each class. With vectoring off, a class behaves as a plain OR of its pending bits and holds no nesting state. The fast class always outranks the normal class.

Top module: `vec_irq_arbiter`

## Requirements
- R1: With the class enabled, its vector reads 0 in bits 31:23 and in bits 1:0. It carries the base input in bits 22:7 and the winning source index in bits 6:2. The index reads 0 when no source is pending.
- R2: The winner is the active source with the numerically smallest priority. Equal priorities resolve to the lower source index.
- R3: With the class enabled, the request is high exactly when a source is pending, the stack is not full, and either the stack is empty or the winner's priority is strictly smaller than the priority at the stack top.
- R4: An acknowledge strobe while the class request is high pushes the priority of the vector just presented, and the level rises by one. An acknowledge while the request is low changes nothing.
- R5: An end-of-interrupt strobe pops one stack entry and lowers the level by one. At level 0 it has no effect.
- R6: When the level equals the stack depth, the class request stays low whatever is pending until a pop occurs.
- R7: With the class disabled (control bit 0 for normal, bit 1 for fast), its request is the OR of its pending bits, its level is 0, its vector is 0, and acknowledges are ignored.
- R8: The normal request is held low while the fast request is high or the fast level is non-zero.
- R9: A synchronous active-high reset clears every output to zero.
- R10: All outputs are registered and reflect the inputs present at the previous rising clock edge.
- R11: An acknowledge and an end-of-interrupt in the same cycle pop first and then push. The level is unchanged and the new top is the acknowledged priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_en | input | 2 | Vectored enable: bit 0 normal class, bit 1 fast class |
| irq_status | input | NUM_SRC | Masked pending sources, normal class |
| fiq_status | input | NUM_SRC | Masked pending sources, fast class |
| prio_cfg | input | NUM_SRC*PRIO_W | Priority of source i in bits [i*PRIO_W +: PRIO_W] |
| vec_base | input | 16 | Handler base field placed in vector bits 22:7 |
| irq_ack | input | 1 | Vector read strobe, normal class |
| irq_eoi | input | 1 | End-of-interrupt write strobe, normal class |
| fiq_ack | input | 1 | Vector read strobe, fast class |
| fiq_eoi | input | 1 | End-of-interrupt write strobe, fast class |
| irq_req | output | 1 | Normal class request |
| fiq_req | output | 1 | Fast class request |
| irq_vector | output | 32 | Normal class vector word |
| fiq_vector | output | 32 | Fast class vector word |
| irq_level | output | LVL_W | Normal class nesting level |
| fiq_level | output | LVL_W | Fast class nesting level |

## Verification
The bench builds the block with 12 sources and a stack depth of 3. This lets a short run of acknowledges fill the stack and test full-stack blocking. It then exercises simultaneous pop and push at the boundary. Twelve sources still leave room for priority ties, preemption chains, a saturated base field, and fast-over-normal masking, each checked against hand-derived vector words.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int IDX_W  = 5;
  localparam int BASE_W = 16;
  localparam int VEC_W  = 32;
  localparam int PAD_W  = VEC_W - BASE_W - IDX_W - 2;

  function automatic logic [VEC_W-1:0] build_vector(input logic [BASE_W-1:0] base,
                                                    input logic [IDX_W-1:0]  idx);
    return {{PAD_W{1'b0}}, base, idx, 2'b00};
  endfunction
endpackage

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3
) (
  input  logic [NUM_SRC-1:0]        active,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
  output logic                      hit,
  output logic [vic_pkg::IDX_W-1:0] win_idx,
  output logic [PRIO_W-1:0]         win_prio
);
  // Scan from the top index down; "<=" lets a lower index take a tie.
  always_comb begin
    hit      = 1'b0;
    win_idx  = '0;
    win_prio = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (active[i] && (!hit || prio_flat[i*PRIO_W +: PRIO_W] <= win_prio)) begin
        hit      = 1'b1;
        win_idx  = vic_pkg::IDX_W'(i);
        win_prio = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/vic_class_unit.sv
module vic_class_unit #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  parameter int DEPTH   = 8,
  parameter int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         enable,
  input  logic [NUM_SRC-1:0]           status,
  input  logic [NUM_SRC*PRIO_W-1:0]    prio_flat,
  input  logic [vic_pkg::BASE_W-1:0]   base,
  input  logic                         ack,
  input  logic                         eoi,
  input  logic                         hold,
  output logic                         req_q,
  output logic [vic_pkg::VEC_W-1:0]    vec_q,
  output logic [LVL_W-1:0]             level_q
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] ONE  = LVL_W'(1);

  logic                      hit;
  logic [vic_pkg::IDX_W-1:0] w_idx;
  logic [PRIO_W-1:0]         w_prio;
  logic [PRIO_W-1:0]         prio_q;
  logic [PRIO_W-1:0]         stk [DEPTH];

  logic                      pop, push, top_valid, preempt, req_d;
  logic [LVL_W-1:0]          lvl_pop, lvl_nxt;
  logic [PRIO_W-1:0]         top_after;

  vic_prio_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) pick_i (
    .active   (status),
    .prio_flat(prio_flat),
    .hit      (hit),
    .win_idx  (w_idx),
    .win_prio (w_prio)
  );

  always_comb begin
    pop     = enable && eoi && (level_q != '0);
    lvl_pop = pop ? (level_q - ONE) : level_q;
    push    = enable && ack && req_q && !hold;
    lvl_nxt = enable ? (push ? (lvl_pop + ONE) : lvl_pop) : '0;
    // Top of the stack as it will stand after this edge.
    if (push)
      top_after = prio_q;
    else if (lvl_pop != '0)
      top_after = stk[PTR_W'(lvl_pop - ONE)];
    else
      top_after = '0;
    top_valid = (lvl_nxt != '0);
    preempt   = hit && (lvl_nxt < FULL) && (!top_valid || (w_prio < top_after));
    req_d     = enable ? preempt : (|status);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      req_q   <= 1'b0;
      vec_q   <= '0;
      prio_q  <= '0;
    end else begin
      level_q <= lvl_nxt;
      req_q   <= req_d;
      vec_q   <= enable ? vic_pkg::build_vector(base, w_idx) : '0;
      prio_q  <= w_prio;
    end
  end

  // Stack storage: one write port, no reset, suited to distributed RAM.
  always_ff @(posedge clk) begin
    if (!rst && push)
      stk[PTR_W'(lvl_pop)] <= prio_q;
  end
endmodule

// File: rtl/vec_irq_arbiter.sv
module vec_irq_arbiter #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  parameter int DEPTH   = 8,
  parameter int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [1:0]                    vec_en,
  input  logic [NUM_SRC-1:0]            irq_status,
  input  logic [NUM_SRC-1:0]            fiq_status,
  input  logic [NUM_SRC*PRIO_W-1:0]     prio_cfg,
  input  logic [vic_pkg::BASE_W-1:0]    vec_base,
  input  logic                          irq_ack,
  input  logic                          irq_eoi,
  input  logic                          fiq_ack,
  input  logic                          fiq_eoi,
  output logic                          irq_req,
  output logic                          fiq_req,
  output logic [vic_pkg::VEC_W-1:0]     irq_vector,
  output logic [vic_pkg::VEC_W-1:0]     fiq_vector,
  output logic [LVL_W-1:0]              irq_level,
  output logic [LVL_W-1:0]              fiq_level
);
  localparam int N_CLASS = 2;  // index 0 normal, index 1 fast

  logic [N_CLASS-1:0][NUM_SRC-1:0]         st;
  logic [N_CLASS-1:0]                      ack_s, eoi_s, hold_s, raw_req;
  logic [N_CLASS-1:0][vic_pkg::VEC_W-1:0]  vec_s;
  logic [N_CLASS-1:0][LVL_W-1:0]           lvl_s;

  assign st[0]    = irq_status;
  assign st[1]    = fiq_status;
  assign ack_s    = {fiq_ack, irq_ack};
  assign eoi_s    = {fiq_eoi, irq_eoi};
  // The fast class masks the normal class while it requests or is in service.
  assign hold_s[0] = raw_req[1] || (lvl_s[1] != '0);
  assign hold_s[1] = 1'b0;

  for (genvar c = 0; c < N_CLASS; c++) begin : g_class
    vic_class_unit #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DEPTH(DEPTH), .LVL_W(LVL_W)
    ) unit_i (
      .clk      (clk),
      .rst      (rst),
      .enable   (vec_en[c]),
      .status   (st[c]),
      .prio_flat(prio_cfg),
      .base     (vec_base),
      .ack      (ack_s[c]),
      .eoi      (eoi_s[c]),
      .hold     (hold_s[c]),
      .req_q    (raw_req[c]),
      .vec_q    (vec_s[c]),
      .level_q  (lvl_s[c])
    );
  end

  assign irq_req    = raw_req[0] && !hold_s[0];
  assign fiq_req    = raw_req[1];
  assign irq_vector = vec_s[0];
  assign fiq_vector = vec_s[1];
  assign irq_level  = lvl_s[0];
  assign fiq_level  = lvl_s[1];
endmodule

// File: rtl/vec_irq_arbiter_chk.sv
module vec_irq_arbiter_chk #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 3,
  parameter int DEPTH   = 8,
  parameter int LVL_W   = $clog2(DEPTH + 1)
) (
  input logic                          clk,
  input logic                          rst,
  input logic [1:0]                    vec_en,
  input logic [NUM_SRC-1:0]            irq_status,
  input logic [NUM_SRC-1:0]            fiq_status,
  input logic [NUM_SRC*PRIO_W-1:0]     prio_cfg,
  input logic [vic_pkg::BASE_W-1:0]    vec_base,
  input logic                          irq_ack,
  input logic                          irq_eoi,
  input logic                          fiq_ack,
  input logic                          fiq_eoi,
  input logic                          irq_req,
  input logic                          fiq_req,
  input logic [vic_pkg::VEC_W-1:0]     irq_vector,
  input logic [vic_pkg::VEC_W-1:0]     fiq_vector,
  input logic [LVL_W-1:0]              irq_level,
  input logic [LVL_W-1:0]              fiq_level
);
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] ONE  = LVL_W'(1);

  AST_VEC_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    irq_vector[1:0] == 2'b00 && irq_vector[31:23] == '0 &&
    fiq_vector[1:0] == 2'b00 && fiq_vector[31:23] == '0); // R1

  AST_ACK_PUSH: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_req && vec_en[0] && !irq_eoi) |=> irq_level == $past(irq_level) + ONE); // R4

  AST_EOI_POP: assert property (@(posedge clk) disable iff (rst)
    (irq_eoi && !irq_ack && vec_en[0] && irq_level != '0) |=> irq_level == $past(irq_level) - ONE); // R5

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
    irq_level <= FULL && fiq_level <= FULL); // R6

  AST_FULL_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (fiq_level == FULL) |-> !fiq_req); // R6

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !vec_en[0] |=> (irq_level == '0 && irq_vector == '0)); // R7

  AST_FAST_MASKS_NORMAL: assert property (@(posedge clk) disable iff (rst)
    $past(fiq_status != '0 && !vec_en[1]) |-> !irq_req); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (!irq_req && !fiq_req && irq_level == '0 && fiq_level == '0 &&
                    irq_vector == '0 && fiq_vector == '0)); // R9
endmodule

bind vec_irq_arbiter vec_irq_arbiter_chk #(
  .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DEPTH(DEPTH), .LVL_W(LVL_W)
) chk_i (.*);

// File: tb/vec_irq_arbiter_tb_top.sv
module vec_irq_arbiter_tb_top;
  localparam int NS    = 12;
  localparam int PW    = 3;
  localparam int DP    = 3;
  localparam int LW    = $clog2(DP + 1);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        vec_en = 2'b01;
  logic [NS-1:0]     irq_status = '0;
  logic [NS-1:0]     fiq_status = '0;
  logic [NS*PW-1:0]  prio_cfg;
  logic [15:0]       vec_base = 16'hABCD;
  logic              irq_ack = 1'b0, irq_eoi = 1'b0, fiq_ack = 1'b0, fiq_eoi = 1'b0;
  logic              irq_req, fiq_req;
  logic [31:0]       irq_vector, fiq_vector;
  logic [LW-1:0]     irq_level, fiq_level;

  logic [PW-1:0]     pr [NS];
  int                checks = 0;
  int                errors = 0;
  bit                done = 1'b0;

  always #5 clk = ~clk;

  always_comb
    for (int i = 0; i < NS; i++) prio_cfg[i*PW +: PW] = pr[i];

  vec_irq_arbiter #(.NUM_SRC(NS), .PRIO_W(PW), .DEPTH(DP)) dut_i (
    .clk(clk), .rst(rst), .vec_en(vec_en),
    .irq_status(irq_status), .fiq_status(fiq_status),
    .prio_cfg(prio_cfg), .vec_base(vec_base),
    .irq_ack(irq_ack), .irq_eoi(irq_eoi), .fiq_ack(fiq_ack), .fiq_eoi(fiq_eoi),
    .irq_req(irq_req), .fiq_req(fiq_req),
    .irq_vector(irq_vector), .fiq_vector(fiq_vector),
    .irq_level(irq_level), .fiq_level(fiq_level)
  );

  typedef struct {
    logic        ireq;
    logic [31:0] ivec;
    int          ilvl;
    logic        freq;
    logic [31:0] fvec;
    int          flvl;
    string       tag;
  } exp_t;

  exp_t sb_q[$];

  function automatic logic [31:0] mkv(input logic [15:0] b, input int idx);
    return {9'b0, b, 5'(idx), 2'b00};
  endfunction

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: queue the expectation for the inputs now applied, advance a cycle.
  task automatic step(input logic ir, input logic [31:0] iv, input int il,
                      input logic fr, input logic [31:0] fv, input int fl,
                      input string tag);
    exp_t e;
    e.ireq = ir; e.ivec = iv; e.ilvl = il;
    e.freq = fr; e.fvec = fv; e.flvl = fl; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    #1;
    irq_ack = 1'b0; irq_eoi = 1'b0; fiq_ack = 1'b0; fiq_eoi = 1'b0;
  endtask

  // Monitor: outputs after the edge that consumed the queued inputs.
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() != 0) begin
        exp_t e;
        e = sb_q.pop_front();
        cmp(e.tag, "irq_req",    32'(irq_req),    32'(e.ireq));
        cmp(e.tag, "irq_vector", irq_vector,      e.ivec);
        cmp(e.tag, "irq_level",  32'(irq_level),  32'(e.ilvl));
        cmp(e.tag, "fiq_req",    32'(fiq_req),    32'(e.freq));
        cmp(e.tag, "fiq_vector", fiq_vector,      e.fvec);
        cmp(e.tag, "fiq_level",  32'(fiq_level),  32'(e.flvl));
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] B;
    B = 16'hABCD;
    for (int i = 0; i < NS; i++) pr[i] = 3'd7;
    pr[1] = 3'd5; pr[3] = 3'd4; pr[5] = 3'd2; pr[7] = 3'd2; pr[9] = 3'd0;

    @(negedge clk); #1;
    step(0, 0, 0, 0, 0, 0, "R9 reset");
    rst = 1'b0;
    step(0, mkv(B, 0), 0, 0, 0, 0, "R1 empty index");
    irq_status = 12'b0000_0000_1010;
    step(1, mkv(B, 3), 0, 0, 0, 0, "R2 R10 pick");
    irq_status = 12'b0000_1010_1000;
    step(1, mkv(B, 5), 0, 0, 0, 0, "R2 tie");
    irq_ack = 1;
    step(0, mkv(B, 5), 1, 0, 0, 0, "R4 R3 push");
    irq_status = 12'b0010_1010_1000;
    step(1, mkv(B, 9), 1, 0, 0, 0, "R3 preempt");
    irq_ack = 1;
    step(0, mkv(B, 9), 2, 0, 0, 0, "R4 push2");
    irq_ack = 1;
    step(0, mkv(B, 9), 2, 0, 0, 0, "R4 ack ignored");
    irq_eoi = 1;
    step(1, mkv(B, 9), 1, 0, 0, 0, "R5 pop");
    irq_status = 12'b0000_0000_0010; irq_eoi = 1;
    step(1, mkv(B, 1), 0, 0, 0, 0, "R5 pop to 0");
    irq_eoi = 1;
    step(1, mkv(B, 1), 0, 0, 0, 0, "R5 eoi at 0");
    irq_ack = 1;
    step(0, mkv(B, 1), 1, 0, 0, 0, "R4 fill1");
    irq_status = 12'b0000_0000_1010;
    step(1, mkv(B, 3), 1, 0, 0, 0, "R3 nest");
    irq_ack = 1;
    step(0, mkv(B, 3), 2, 0, 0, 0, "R4 fill2");
    irq_status = 12'b0000_0010_1010;
    step(1, mkv(B, 5), 2, 0, 0, 0, "R3 nest2");
    irq_ack = 1;
    step(0, mkv(B, 5), 3, 0, 0, 0, "R6 fill3");
    irq_status = 12'b0010_0010_1010;
    step(0, mkv(B, 9), 3, 0, 0, 0, "R6 full blocks");
    irq_eoi = 1;
    step(1, mkv(B, 9), 2, 0, 0, 0, "R6 pop unblocks");
    irq_ack = 1; irq_eoi = 1;
    step(0, mkv(B, 9), 2, 0, 0, 0, "R11 pop push");
    irq_eoi = 1;
    step(1, mkv(B, 9), 1, 0, 0, 0, "R11 top replaced");
    vec_en = 2'b11; fiq_status = 12'b0000_0100_0000;
    step(0, mkv(B, 9), 1, 1, mkv(B, 6), 0, "R8 fast req");
    fiq_ack = 1;
    step(0, mkv(B, 9), 1, 0, mkv(B, 6), 1, "R8 fast level");
    fiq_eoi = 1; fiq_status = '0;
    step(1, mkv(B, 9), 1, 0, mkv(B, 0), 0, "R8 released");
    vec_en = 2'b00; irq_status = 12'b0000_0000_1000; fiq_status = 12'b0000_0000_0100;
    step(0, 0, 0, 1, 0, 0, "R7 disabled");
    fiq_status = '0;
    step(1, 0, 0, 0, 0, 0, "R7 plain or");
    irq_ack = 1;
    step(1, 0, 0, 0, 0, 0, "R7 ack ignored");
    vec_en = 2'b01; vec_base = 16'hFFFF;
    step(1, mkv(16'hFFFF, 3), 0, 0, 0, 0, "R1 full base");

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule